// File: doc/BRIEF.md
# SPI DAC Write Sequencer

This block turns one request (a channel address and a 12-bit output code) into a complete update of a multichannel DAC over a write-only serial link. The link has three lines: a serial clock, a serial data line and an active-low chip select. The request arrives on a valid/ready port. The block builds a 24-bit write frame and shifts it out most significant bit first. The serial clock comes from the system clock through a parameterized divider. Data changes only on rising clock edges, so the DAC can sample it cleanly on falling edges.

After the last bit the block releases chip select. It waits a set number of system cycles and then pulses an active-low load strobe. This copies the new code to the analog output. Ready returns only after the strobe has gone high again and chip select has stayed high for at least one full serial clock period. A request that arrives during this sequence waits on a low ready and is taken whole afterwards.

Top module: `dac_spi_seq`

## Requirements
- R1: A synchronous active-high reset, with or without a frame in progress, drives chip select high, the load strobe high, the serial clock low and the data line low, and leaves the block idle with ready high.
- R2: Each accepted request produces exactly 24 falling serial clock edges during one low period of chip select.
- R3: The frame is sent most significant bit first. In transmission order it is 4 zero command bits, then the 4-bit address, then the 12-bit code, then 4 zero pad bits.
- R4: The data line changes only together with a rising serial clock edge while chip select is low. It is low while chip select is high. The first bit is driven from the moment chip select falls.
- R5: Every high and low phase of the serial clock lasts HALF_DIV system cycles. This includes the low phase from the chip select fall to the first rising edge and the low phase from the last falling edge to the chip select rise. The serial clock stays low while chip select is high.
- R6: The load strobe falls exactly CS_GAP_CYC system cycles after chip select rises. It is never low while chip select is low.
- R7: The load strobe stays low for exactly LOAD_W system cycles and then returns high.
- R8: Ready is low from acceptance until 2*HALF_DIV system cycles after the load strobe returns high. Chip select therefore stays high for at least one serial clock period between frames.
- R9: A request held valid while a frame is in progress is neither dropped nor merged. It is sent as the next complete frame, with its own address and code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | ADDR_W | DAC channel address |
| req_code | input | CODE_W | Output code for the channel |
| dac_sclk | output | 1 | Serial clock, idles low |
| dac_sdi | output | 1 | Serial data, set up for falling-edge sampling |
| dac_cs_n | output | 1 | Active-low chip select |
| dac_load_n | output | 1 | Active-low load strobe |

## Verification
Two cases are the hardest to reach from the ports. The first is a request that is already pending while a frame is being shifted. The bench holds valid high and swaps in a second payload as soon as chip select falls for the first frame, so the second request sits waiting through the shift, gap, strobe and tail phases. The second case is a reset that lands mid-frame with the serial clock possibly high. The bench counts into the shift phase before it asserts reset and then checks that a clean frame follows. Every frame is rebuilt from the sampled falling edges and compared with the expected bit pattern. The phase lengths are measured in system cycles at the pins.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEAD,
      ST_SHIFT,
      ST_GAP,
      ST_LOAD,
      ST_TAIL
   } seq_state_t;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dac_half_tick.sv
module dac_half_tick #(
   parameter int HALF_DIV = 5
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic tick
);
   localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

   if (HALF_DIV < 1) begin : g_bad_div
      $error("HALF_DIV must be at least 1");
   end

   if (HALF_DIV == 1) begin : g_every_cycle
      assign tick = run;
   end else begin : g_counted
      localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
         if (rst || !run) begin
            cnt <= '0;
         end else if (cnt == LAST) begin
            cnt <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end

      assign tick = run && (cnt == LAST);

      // R5
      cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
         cnt <= LAST);
   end

endmodule

// File: rtl/dac_frame_sreg.sv
module dac_frame_sreg #(
   parameter int CMD_W     = 4,
   parameter int ADDR_W    = 4,
   parameter int CODE_W    = 12,
   parameter int PAD_W     = 4,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic              shift,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CODE_W-1:0] code,
   output logic              bit_out
);
   localparam int FRAME_W = CMD_W + ADDR_W + CODE_W + PAD_W;
   localparam int SCW     = $clog2(FRAME_W + 1);

   if (ADDR_W < 1 || CODE_W < 1 || CMD_W < 0 || PAD_W < 0) begin : g_bad_fields
      $error("frame field widths out of range");
   end

   logic [FRAME_W-1:0] frame_in;
   logic [FRAME_W-1:0] sreg;
   logic [SCW-1:0]     shifts_done;

   if (PAD_W > 0 && CMD_W > 0) begin : g_cmd_pad
      assign frame_in = {{CMD_W{1'b0}}, addr, code, {PAD_W{1'b0}}};
   end else if (CMD_W > 0) begin : g_cmd_only
      assign frame_in = {{CMD_W{1'b0}}, addr, code};
   end else if (PAD_W > 0) begin : g_pad_only
      assign frame_in = {addr, code, {PAD_W{1'b0}}};
   end else begin : g_bare
      assign frame_in = {addr, code};
   end

   if (MSB_FIRST) begin : g_msb
      always_ff @(posedge clk) begin
         if (rst) begin
            sreg <= '0;
         end else if (load) begin
            sreg <= frame_in;
         end else if (shift) begin
            sreg <= {sreg[FRAME_W-2:0], 1'b0};
         end
      end
      assign bit_out = sreg[FRAME_W-1];
   end else begin : g_lsb
      always_ff @(posedge clk) begin
         if (rst) begin
            sreg <= '0;
         end else if (load) begin
            sreg <= frame_in;
         end else if (shift) begin
            sreg <= {1'b0, sreg[FRAME_W-1:1]};
         end
      end
      assign bit_out = sreg[0];
   end

   always_ff @(posedge clk) begin
      if (rst || load) begin
         shifts_done <= '0;
      end else if (shift) begin
         shifts_done <= shifts_done + 1'b1;
      end
   end

   // R2
   shift_bound_chk: assert property (@(posedge clk) disable iff (rst)
      shift |-> (shifts_done < SCW'(FRAME_W - 1)));

endmodule

// File: rtl/dac_wait_cnt.sv
module dac_wait_cnt #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         start,
   input  logic [W-1:0] start_val,
   output logic         done
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
      end else if (start) begin
         cnt <= start_val;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign done = (cnt == '0);

   // R7
   done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (done && !start) |=> done);

endmodule

// File: rtl/dac_spi_seq.sv
module dac_spi_seq
   import dac_seq_pkg::*;
#(
   parameter int HALF_DIV   = 5,
   parameter int ADDR_W     = 4,
   parameter int CODE_W     = 12,
   parameter int CMD_W      = 4,
   parameter int PAD_W      = 4,
   parameter int CS_GAP_CYC = 3,
   parameter int LOAD_W     = 3,
   parameter bit MSB_FIRST  = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [CODE_W-1:0] req_code,
   output logic              dac_sclk,
   output logic              dac_sdi,
   output logic              dac_cs_n,
   output logic              dac_load_n
);
   localparam int FRAME_W  = CMD_W + ADDR_W + CODE_W + PAD_W;
   localparam int HALVES   = 2 * FRAME_W;
   localparam int HW       = $clog2(HALVES);
   localparam int TAIL_CYC = 2 * HALF_DIV;
   localparam int WMAX     = imax(imax(CS_GAP_CYC, LOAD_W), TAIL_CYC);
   localparam int WW       = $clog2(WMAX + 1);
   localparam logic [HW-1:0] LAST_HALF = HW'(HALVES - 1);

   if (CS_GAP_CYC < 1) begin : g_bad_gap
      $error("CS_GAP_CYC must be at least 1");
   end
   if (LOAD_W < 1) begin : g_bad_load
      $error("LOAD_W must be at least 1");
   end

   seq_state_t    state;
   logic [HW-1:0] hidx;
   logic          sclk_q;
   logic          cs_n_q;
   logic          load_n_q;
   logic          half_run;
   logic          tick;
   logic          sreg_load;
   logic          sreg_shift;
   logic          sreg_bit;
   logic          wait_start;
   logic [WW-1:0] wait_val;
   logic          wait_done;

   assign half_run   = (state == ST_LEAD) || (state == ST_SHIFT);
   assign sreg_load  = (state == ST_IDLE) && req_valid;
   assign sreg_shift = (state == ST_SHIFT) && tick && hidx[0] && (hidx != LAST_HALF);

   always_comb begin
      wait_start = 1'b0;
      wait_val   = '0;
      if ((state == ST_SHIFT) && tick && (hidx == LAST_HALF)) begin
         wait_start = 1'b1;
         wait_val   = WW'(CS_GAP_CYC - 1);
      end else if ((state == ST_GAP) && wait_done) begin
         wait_start = 1'b1;
         wait_val   = WW'(LOAD_W - 1);
      end else if ((state == ST_LOAD) && wait_done) begin
         wait_start = 1'b1;
         wait_val   = WW'(TAIL_CYC - 1);
      end
   end

   dac_half_tick #(
      .HALF_DIV (HALF_DIV)
   ) i_half_tick (
      .clk  (clk),
      .rst  (rst),
      .run  (half_run),
      .tick (tick)
   );

   dac_frame_sreg #(
      .CMD_W     (CMD_W),
      .ADDR_W    (ADDR_W),
      .CODE_W    (CODE_W),
      .PAD_W     (PAD_W),
      .MSB_FIRST (MSB_FIRST)
   ) i_frame_sreg (
      .clk     (clk),
      .rst     (rst),
      .load    (sreg_load),
      .shift   (sreg_shift),
      .addr    (req_addr),
      .code    (req_code),
      .bit_out (sreg_bit)
   );

   dac_wait_cnt #(
      .W (WW)
   ) i_wait_cnt (
      .clk       (clk),
      .rst       (rst),
      .start     (wait_start),
      .start_val (wait_val),
      .done      (wait_done)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= ST_IDLE;
         hidx     <= '0;
         sclk_q   <= 1'b0;
         cs_n_q   <= 1'b1;
         load_n_q <= 1'b1;
      end else begin
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  cs_n_q <= 1'b0;
                  state  <= ST_LEAD;
               end
            end
            ST_LEAD: begin
               if (tick) begin
                  sclk_q <= 1'b1;
                  hidx   <= '0;
                  state  <= ST_SHIFT;
               end
            end
            ST_SHIFT: begin
               if (tick) begin
                  if (!hidx[0]) begin
                     sclk_q <= 1'b0;
                     hidx   <= hidx + 1'b1;
                  end else if (hidx == LAST_HALF) begin
                     cs_n_q <= 1'b1;
                     state  <= ST_GAP;
                  end else begin
                     sclk_q <= 1'b1;
                     hidx   <= hidx + 1'b1;
                  end
               end
            end
            ST_GAP: begin
               if (wait_done) begin
                  load_n_q <= 1'b0;
                  state    <= ST_LOAD;
               end
            end
            ST_LOAD: begin
               if (wait_done) begin
                  load_n_q <= 1'b1;
                  state    <= ST_TAIL;
               end
            end
            ST_TAIL: begin
               if (wait_done) begin
                  state <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign req_ready  = (state == ST_IDLE);
   assign dac_sclk   = sclk_q;
   assign dac_cs_n   = cs_n_q;
   assign dac_load_n = load_n_q;
   assign dac_sdi    = sreg_bit & ~cs_n_q;

   // R5
   sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
      dac_cs_n |-> !dac_sclk);

   // R6
   load_needs_cs_high_chk: assert property (@(posedge clk) disable iff (rst)
      !dac_load_n |-> dac_cs_n);

   // R6
   load_after_release_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(dac_load_n) |-> $past(dac_cs_n));

   // R4
   sdi_low_phase_chk: assert property (@(posedge clk) disable iff (rst)
      (!dac_cs_n && $past(!dac_cs_n) && !dac_sclk) |-> $stable(dac_sdi));

   // R8
   ready_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      req_ready |-> (dac_cs_n && dac_load_n && !dac_sclk));

   // R9
   hold_off_chk: assert property (@(posedge clk) disable iff (rst)
      (!dac_cs_n && $past(!dac_cs_n)) |-> !req_ready);

endmodule

// File: tb/test_dac_spi_seq.sv
module test_dac_spi_seq;
   localparam int H = 5;
   localparam int G = 3;
   localparam int L = 3;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [3:0]  req_addr = '0;
   logic [11:0] req_code = '0;
   logic        dac_sclk, dac_sdi, dac_cs_n, dac_load_n;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;

   always #5 clk = ~clk;

   dac_spi_seq #(
      .HALF_DIV   (H),
      .CS_GAP_CYC (G),
      .LOAD_W     (L)
   ) i_dac_spi_seq (
      .clk        (clk),
      .rst        (rst),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_addr   (req_addr),
      .req_code   (req_code),
      .dac_sclk   (dac_sclk),
      .dac_sdi    (dac_sdi),
      .dac_cs_n   (dac_cs_n),
      .dac_load_n (dac_load_n)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: actual %0d expected below 150000", cycles);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   // Observes one frame at the pins; applies the next request state when chip select falls.
   task automatic capture_check(input logic nv, input logic [3:0] na, input logic [11:0] nc,
                                input logic [3:0] ea, input logic [11:0] ec);
      logic [23:0] bits = '0;
      int falls = 0, bad_half = 0, sdi_bad = 0, rdy_bad = 0, idle_bad = 0;
      int run, gap, lw, tail;
      logic ps, pd;
      do @(negedge clk); while (dac_cs_n);
      req_valid = nv;
      req_addr  = na;
      req_code  = nc;
      run = 1;
      ps  = dac_sclk;
      pd  = dac_sdi;
      if (ps) bad_half++;
      forever begin
         @(negedge clk);
         if (dac_cs_n) begin
            if (run != H) bad_half++;
            break;
         end
         if (req_ready) rdy_bad++;
         if (dac_sclk != ps) begin
            if (run != H) bad_half++;
            if (ps && !dac_sclk) begin
               bits = {bits[22:0], pd};
               falls++;
            end
            run = 1;
         end else begin
            run++;
         end
         if (dac_sdi != pd && !(dac_sclk && !ps)) sdi_bad++;
         ps = dac_sclk;
         pd = dac_sdi;
      end
      gap = 0;
      while (dac_load_n) begin
         gap++;
         if (req_ready) rdy_bad++;
         if (dac_sclk || dac_sdi) idle_bad++;
         @(negedge clk);
      end
      lw = 0;
      while (!dac_load_n) begin
         lw++;
         if (req_ready || !dac_cs_n) rdy_bad++;
         if (dac_sclk || dac_sdi) idle_bad++;
         @(negedge clk);
      end
      tail = 0;
      while (!req_ready) begin
         tail++;
         if (!dac_cs_n || dac_sclk || dac_sdi) idle_bad++;
         @(negedge clk);
      end
      check(falls == 24, "R2 falling edges per frame", falls, 24);
      check(bits == {4'h0, ea, ec, 4'h0}, "R3 frame bits", bits, {4'h0, ea, ec, 4'h0});
      check(sdi_bad == 0, "R4 sdi changes off rising edge", sdi_bad, 0);
      check(bad_half == 0, "R5 sclk phase length", bad_half, 0);
      check(idle_bad == 0, "R5 sclk/sdi low while cs high", idle_bad, 0);
      check(gap == G, "R6 cs rise to load fall", gap, G);
      check(lw == L, "R7 load width", lw, L);
      check(tail == 2 * H, "R8 load release to ready", tail, 2 * H);
      check(rdy_bad == 0, "R8 ready low while busy", rdy_bad, 0);
   endtask

   task automatic t_reset_state();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      check(dac_cs_n == 1'b1, "R1 cs_n in reset", dac_cs_n, 1);
      check(dac_load_n == 1'b1, "R1 load_n in reset", dac_load_n, 1);
      check(dac_sclk == 1'b0, "R1 sclk in reset", dac_sclk, 0);
      rst = 1'b0;
      @(negedge clk);
      check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
      check(dac_sdi == 1'b0, "R1 sdi after reset", dac_sdi, 0);
   endtask

   task automatic t_single(input logic [3:0] a, input logic [11:0] c);
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = a;
      req_code  = c;
      capture_check(1'b0, 4'h0, 12'h000, a, c);
   endtask

   // R9: second request stays valid through the whole first frame
   task automatic t_back_to_back();
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = 4'h6;
      req_code  = 12'h3C1;
      capture_check(1'b1, 4'h9, 12'hE07, 4'h6, 12'h3C1);
      capture_check(1'b0, 4'h0, 12'h000, 4'h9, 12'hE07);
   endtask

   task automatic t_reset_midframe();
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = 4'hA;
      req_code  = 12'h5A5;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (62) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check(dac_cs_n == 1'b1, "R1 cs_n after mid-frame reset", dac_cs_n, 1);
      check(dac_sclk == 1'b0, "R1 sclk after mid-frame reset", dac_sclk, 0);
      check(dac_load_n == 1'b1, "R1 load_n after mid-frame reset", dac_load_n, 1);
      check(req_ready == 1'b1, "R1 ready after mid-frame reset", req_ready, 1);
      check(dac_sdi == 1'b0, "R1 sdi after mid-frame reset", dac_sdi, 0);
      repeat (4) @(negedge clk);
      check(dac_cs_n == 1'b1, "R1 no frame resumes after reset", dac_cs_n, 1);
   endtask

   initial begin
      t_reset_state();
      t_single(4'h4, 12'hFFF);
      t_single(4'h5, 12'hA5C);
      t_single(4'hF, 12'h000);
      t_single(4'h0, 12'h801);
      t_back_to_back();
      t_reset_midframe();
      t_single(4'h3, 12'h7FE);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule